// File: doc/BRIEF.md
# Wake Trigger Converter

A bank of interrupt lines, each of which may be sensitive to a high level, a low level, a rising edge, a falling edge or both edges. Every line is converted to one of two plain forms, an active-high level or a rising-edge pulse one clock wide. The controller downstream therefore only needs to handle high levels and rising edges, and never needs per-line polarity setup.

Each input first passes through a synchroniser chain of `SYNC_STAGES` flops. Edge modes compare the newest synchronised sample with the one before it. Level modes pass the synchronised sample through, inverted when the line is active low, with no latching. Software controls the block through a word-addressed register port. The port holds one enable bit per line, packed 32 lines to a word, and one 3-bit trigger code per line. A line whose enable bit is clear never drives its output.

Top module: `wake_trig_conv`

## Requirements
- R1: Line n's enable bit is bit n%32 of the word at byte address 0x10 + 4*(n/32). Line n's trigger code sits in bits [2:0] of the word at 0x110 + 4*n, and the upper bits of that word read as zero. Enable bits for lines at or above NUM_LINES read as zero. A read captures the addressed word into `rdata` on the clock edge where `rd_en` is high, and `rdata` holds between reads.
- R2: After reset, every enable bit is 0, every trigger code is 000 and every output is low.
- R3: A line whose enable bit is 0 keeps its output low for every input value and every trigger code.
- R4: Code 100 (level, active high): the output equals the input delayed by SYNC_STAGES clock edges.
- R5: Code 000 (level, active low): the output equals the inverted input delayed by SYNC_STAGES clock edges.
- R6: Code 110 (rising edge): each 0-to-1 input transition gives exactly one output cycle high, starting SYNC_STAGES edges after the new value is first sampled. Falling transitions give nothing.
- R7: Code 010 (falling edge): each 1-to-0 input transition gives exactly one output cycle high, with the same latency as R6. Rising transitions give nothing.
- R8: Code 111 (both edges): every input transition in either direction gives one output cycle high, with the same latency as R6.
- R9: Codes 001, 011 and 101 keep the output low.
- R10: Lines are independent: one line's input, enable and code never change another line's output.
- R11: A write to an address outside both register ranges has no effect, and neither does a write whose addr[1:0] is not 00. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| line_in | input | NUM_LINES | Raw interrupt inputs |
| line_out | output | NUM_LINES | Normalised outputs toward the parent controller |

## Verification
The bench covers every one of the eight trigger codes on lines at both ends of each enable word, including the partial last word. It samples the cycle of the transition and the cycle after it, so a pulse that stretches to two cycles, comes a cycle early or late, or fires on the wrong edge shows up as a mismatch. It checks the reset state while inputs are low and codes are 000, the case where a design that forgets enable gating would raise every output. It also checks words past the last line, misaligned addresses and a mix of active-low and active-high lines under dense input patterns, which exposes crosstalk, aliasing in the decode and a missing inversion.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   localparam int unsigned WORD_BITS      = 32;
   localparam int unsigned MAX_LINES      = 168;
   localparam int unsigned EN_BASE_ADDR   = 32'h0000_0010;
   localparam int unsigned CFG_BASE_ADDR  = 32'h0000_0110;
   localparam int unsigned CODE_W         = 3;

   typedef enum logic [CODE_W-1:0] {
      TRIG_LVL_LO = 3'b000,
      TRIG_FALL   = 3'b010,
      TRIG_LVL_HI = 3'b100,
      TRIG_RISE   = 3'b110,
      TRIG_BOTH   = 3'b111
   } trig_mode_e;
endpackage

// File: rtl/wtc_sync.sv
module wtc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic cur,
   output logic prev
);
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], d};
   end

   assign cur  = chain_q[STAGES-1];
   assign prev = chain_q[STAGES];
endmodule

// File: rtl/wtc_shaper.sv
module wtc_shaper
   import wtc_pkg::*;
(
   input  logic [CODE_W-1:0] mode,
   input  logic              enable,
   input  logic              cur,
   input  logic              prev,
   output logic              fire
);
   logic rose, fell, raw;

   assign rose = cur & ~prev;
   assign fell = ~cur & prev;

   always_comb begin
      raw = 1'b0;
      case (mode)
         TRIG_LVL_LO: raw = ~cur;
         TRIG_LVL_HI: raw = cur;
         TRIG_FALL:   raw = fell;
         TRIG_RISE:   raw = rose;
         TRIG_BOTH:   raw = rose | fell;
         default:     raw = 1'b0;
      endcase
      fire = enable & raw;
   end
endmodule

// File: rtl/wtc_regs.sv
module wtc_regs
   import wtc_pkg::*;
#(
   parameter int NUM_LINES = 168,
   parameter int ADDR_W    = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [WORD_BITS-1:0]        wdata,
   output logic [WORD_BITS-1:0]        rdata,
   output logic [NUM_LINES-1:0]        en_o,
   output logic [NUM_LINES*CODE_W-1:0] cfg_o
);
   localparam int WA_W     = ADDR_W - 2;
   localparam int EN_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS;
   localparam int EN_W0    = EN_BASE_ADDR / 4;
   localparam int CFG_W0   = CFG_BASE_ADDR / 4;

   logic [WA_W-1:0]               wa;
   logic                          aligned;
   logic                          wr_ok;
   logic [EN_WORDS*WORD_BITS-1:0] en_pad;
   logic [WORD_BITS-1:0]          rd_val;

   assign wa      = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign wr_ok   = wr_en & aligned;

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      localparam logic [WA_W-1:0] MY_EN  = WA_W'(EN_W0 + n / WORD_BITS);
      localparam logic [WA_W-1:0] MY_CFG = WA_W'(CFG_W0 + n);
      localparam int              BIT    = n % WORD_BITS;
      logic              en_r;
      logic [CODE_W-1:0] cfg_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r  <= 1'b0;
            cfg_r <= '0;
         end else if (wr_ok) begin
            if (wa == MY_EN)  en_r  <= wdata[BIT];
            if (wa == MY_CFG) cfg_r <= wdata[CODE_W-1:0];
         end
      end

      assign en_o[n]               = en_r;
      assign cfg_o[n*CODE_W +: CODE_W] = cfg_r;
   end

   always_comb begin
      en_pad = '0;
      en_pad[NUM_LINES-1:0] = en_o;
   end

   always_comb begin
      rd_val = '0;
      if (aligned) begin
         for (int k = 0; k < EN_WORDS; k++)
            if (wa == WA_W'(EN_W0 + k)) rd_val = en_pad[k*WORD_BITS +: WORD_BITS];
         for (int n = 0; n < NUM_LINES; n++)
            if (wa == WA_W'(CFG_W0 + n))
               rd_val = {{(WORD_BITS-CODE_W){1'b0}}, cfg_o[n*CODE_W +: CODE_W]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end
endmodule

// File: rtl/wake_trig_conv.sv
module wake_trig_conv
   import wtc_pkg::*;
#(
   parameter int NUM_LINES   = 168,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic [NUM_LINES-1:0] line_in,
   output logic [NUM_LINES-1:0] line_out
);
   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("wake_trig_conv: NUM_LINES out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wake_trig_conv: SYNC_STAGES must be at least 2");
   end
   if (CFG_BASE_ADDR + 4 * NUM_LINES > (1 << ADDR_W)) begin : g_bad_addr
      $error("wake_trig_conv: ADDR_W too narrow for configuration words");
   end

   logic [NUM_LINES-1:0]        en_bits;
   logic [NUM_LINES*CODE_W-1:0] cfg_bits;

   wtc_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .en_o  (en_bits),
      .cfg_o (cfg_bits)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_path
      logic s_cur, s_prev;

      wtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (line_in[n]),
         .cur   (s_cur),
         .prev  (s_prev)
      );

      wtc_shaper u_shape (
         .mode   (cfg_bits[n*CODE_W +: CODE_W]),
         .enable (en_bits[n]),
         .cur    (s_cur),
         .prev   (s_prev),
         .fire   (line_out[n])
      );
   end
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk
   import wtc_pkg::*;
#(
   parameter int NUM_LINES   = 168,
   parameter int SYNC_STAGES = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_LINES-1:0]        line_in,
   input logic [NUM_LINES-1:0]        line_out,
   input logic [NUM_LINES-1:0]        en_all,
   input logic [NUM_LINES*CODE_W-1:0] cfg_all
);
   logic [NUM_LINES-1:0] prev_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_in <= '0;
      else        prev_in <= line_in;
   end

   // R3
   disabled_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_out & ~en_all) == '0);

   // R2
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_all == '0 && cfg_all == '0));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
      logic [CODE_W-1:0] c;
      logic [3:0]        stab;
      logic              settled;

      assign c = cfg_all[i*CODE_W +: CODE_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      stab <= '0;
         else if (line_in[i] != prev_in[i]) stab <= '0;
         else if (stab != 4'hF)           stab <= stab + 4'd1;
      end

      assign settled = (line_in[i] == prev_in[i]) && (int'(stab) >= SYNC_STAGES - 1);

      // R9
      undefined_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c == 3'b001 || c == 3'b011 || c == 3'b101) |-> !line_out[i]);

      // R6
      rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c == TRIG_RISE && line_out[i]) |=> (c != TRIG_RISE || !line_out[i]));

      // R7
      fall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c == TRIG_FALL && line_out[i]) |=> (c != TRIG_FALL || !line_out[i]));

      // R4
      level_high_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c == TRIG_LVL_HI && en_all[i] && settled) |-> (line_out[i] == line_in[i]));

      // R5
      level_low_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c == TRIG_LVL_LO && en_all[i] && settled) |-> (line_out[i] == !line_in[i]));
   end
endmodule

bind wake_trig_conv wtc_chk #(
   .NUM_LINES   (NUM_LINES),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .line_in  (line_in),
   .line_out (line_out),
   .en_all   (en_bits),
   .cfg_all  (cfg_bits)
);

// File: tb/sim_wake_trig_conv.sv
`timescale 1ns/1ps
module sim_wake_trig_conv;
   localparam int NL = 40;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NL-1:0] lin = '0;
   logic [NL-1:0] lout;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wake_trig_conv #(.NUM_LINES(NL), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .line_in(lin), .line_out(lout)
   );

   task automatic chk_v(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: line_out=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_w(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rdata=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   // wait until the synchronised value of an input driven at this negedge is visible
   task automatic settle2();
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   // phase 0 steady low, 1 cycle after rise, 2 steady high, 3 cycle after fall, 4 steady low
   function automatic bit exp_out(input logic [2:0] c, input int ph);
      case (ph)
         0: return c == 3'b000;
         1: return c == 3'b100 || c == 3'b110 || c == 3'b111;
         2: return c == 3'b100;
         3: return c == 3'b000 || c == 3'b010 || c == 3'b111;
         default: return c == 3'b000;
      endcase
   endfunction

   function automatic string code_tag(input logic [2:0] c);
      case (c)
         3'b000: return "R5 level-low";
         3'b010: return "R7 falling";
         3'b100: return "R4 level-high";
         3'b110: return "R6 rising";
         3'b111: return "R8 both-edges";
         default: return "R9 undefined-code";
      endcase
   endfunction

   task automatic run_phases(input int ln, input logic [2:0] c, input bit on, input string tag);
      logic [NL-1:0] one;
      one = '0; one[ln] = 1'b1;
      repeat (4) @(negedge clk);
      chk_v($sformatf("%s line %0d code %b ph0", tag, ln, c), lout, (on && exp_out(c, 0)) ? one : '0);
      lin[ln] = 1'b1;
      settle2();
      chk_v($sformatf("%s line %0d code %b ph1", tag, ln, c), lout, (on && exp_out(c, 1)) ? one : '0);
      @(negedge clk);
      chk_v($sformatf("%s line %0d code %b ph2", tag, ln, c), lout, (on && exp_out(c, 2)) ? one : '0);
      lin[ln] = 1'b0;
      settle2();
      chk_v($sformatf("%s line %0d code %b ph3", tag, ln, c), lout, (on && exp_out(c, 3)) ? one : '0);
      @(negedge clk);
      chk_v($sformatf("%s line %0d code %b ph4", tag, ln, c), lout, (on && exp_out(c, 4)) ? one : '0);
   endtask

   initial begin
      #(500000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [NL-1:0] pat;
      logic [NL-1:0] odd;
      int lines [5] = '{0, 17, 31, 32, 39};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: enables clear although inputs low and codes 000 would raise every output
      chk_v("R2 outputs after reset", lout, '0);
      rd(32'h10, r);  chk_w("R2 enable word 0 after reset", r, 32'h0);
      rd(32'h14, r);  chk_w("R2 enable word 1 after reset", r, 32'h0);
      rd(32'h110, r); chk_w("R2 code line 0 after reset", r, 32'h0);
      rd(32'h110 + 4*39, r); chk_w("R2 code line 39 after reset", r, 32'h0);

      // R1 register map and readback
      wr(32'h10, 32'hDEAD_BEEF);
      rd(32'h10, r);  chk_w("R1 enable word 0 readback", r, 32'hDEAD_BEEF);
      wr(32'h14, 32'hFFFF_FFFF);
      rd(32'h14, r);  chk_w("R1 enable word 1 bits past last line", r, 32'h0000_00FF);
      wr(32'h110 + 4*7, 32'hFFFF_FFFD);
      rd(32'h110 + 4*7, r); chk_w("R1 code word upper bits", r, 32'h5);
      @(negedge clk);
      chk_w("R1 rdata holds without rd_en", rdata, 32'h5);

      // R11 unmapped and misaligned accesses
      wr(32'h18, 32'hFFFF_FFFF);
      rd(32'h18, r);  chk_w("R11 unmapped enable word", r, 32'h0);
      wr(32'h110 + 4*NL, 32'h7);
      rd(32'h110 + 4*NL, r); chk_w("R11 code word past last line", r, 32'h0);
      wr(32'h110, 32'h0);
      wr(32'h111, 32'h7);
      rd(32'h110, r); chk_w("R11 misaligned write ignored", r, 32'h0);
      rd(32'h111, r); chk_w("R11 misaligned read zero", r, 32'h0);
      rd(32'h0, r);   chk_w("R11 address zero reads zero", r, 32'h0);

      wr(32'h10, 32'h0);
      wr(32'h14, 32'h0);
      wr(32'h110 + 4*7, 32'h0);

      // sweep every code on lines at word edges, enabled (R4-R9) and disabled (R3)
      foreach (lines[i]) begin
         for (int c = 0; c < 8; c++) begin
            int ln = lines[i];
            wr(32'h10, ln < 32 ? (32'h1 << ln) : 32'h0);
            wr(32'h14, ln >= 32 ? (32'h1 << (ln - 32)) : 32'h0);
            wr(32'h110 + 4*ln, 32'(c));
            run_phases(ln, 3'(c), 1'b1, code_tag(3'(c)));
         end
         wr(32'h110 + 4*lines[i], 32'h0);
      end

      wr(32'h10, 32'h0);
      wr(32'h14, 32'h0);
      for (int c = 0; c < 8; c++) begin
         wr(32'h110 + 4*5, 32'(c));
         run_phases(5, 3'(c), 1'b0, "R3 disabled");
      end

      // R10 all lines together, odd lines active low, even lines active high
      odd = '0;
      for (int n = 0; n < NL; n++) begin
         wr(32'h110 + 4*n, (n % 2) ? 32'h0 : 32'h4);
         odd[n] = (n % 2) != 0;
      end
      wr(32'h10, 32'hFFFF_FFFF);
      wr(32'h14, 32'hFFFF_FFFF);
      pat = 40'hA5_5A3C_C3F0;
      @(negedge clk); lin = pat; settle2();
      chk_v("R10 mixed polarity pattern A", lout, pat ^ odd);
      pat = 40'h3C_0FF0_9669;
      lin = pat; settle2();
      chk_v("R10 mixed polarity pattern B", lout, pat ^ odd);
      wr(32'h10, 32'h0);
      chk_v("R3 word 0 disabled keeps upper lines", lout, (pat ^ odd) & 40'hFF_0000_0000);
      lin = '0; settle2();
      chk_v("R10 inputs low", lout, odd & 40'hFF_0000_0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule